// File: doc/BRIEF.md
# Orientation Detector with Debounced State Change

This block turns a stream of signed three-axis acceleration samples into a screen-orientation state. Each time the output-data-rate strobe arrives, it classifies the sample into one of six orientations. Four of them are rotation states: the X axis pointing down or up, and the Y axis pointing down or up. The other two are the face states, screen up and screen down. Before a candidate replaces the reported state, it has to persist for a programmable number of samples.

The rotation states are reached only when one in-plane axis clearly dominates the other. The thresholds form a band around the 45° boundary, so a device held near the diagonal keeps its reported state instead of flickering. When the larger in-plane magnitude falls under the tilt limit, the device is treated as lying flat, and the sign of Z picks between face-up and face-down.

All thresholds arrive as register values. The block keeps current and previous one-hot state registers. For the interrupt logic it produces two one-cycle pulses:
- a change pulse on every accepted transition;
- an interrupt pulse, which is additionally gated by a per-state mask.

While software is reading the state registers, they are frozen.

Top module: `orient_detector`

## Requirements
- R1: Both state outputs are one-hot in bits 5..0, with bit 5 = left (X negative), bit 4 = right (X positive), bit 3 = down (Y negative), bit 2 = up (Y positive), bit 1 = face-down, bit 0 = face-up. Bits 7..6 are always zero. After reset, both outputs are 8'h20 and both pulses are low.
- R2: The state outputs change only at a clock edge where a sample event is applied (a strobe, or a held-over strobe). The new value is visible right after that edge, and input changes without an event have no effect.
- R3: Let the in-plane magnitude be max(|X|,|Y|). If it is strictly below `tilt_limit`, the candidate is face-up when Z >= 0 and face-down when Z < 0. A magnitude equal to the limit does not count as flat.
- R4: Otherwise the candidate is chosen as follows:
  - |X| > `axis_enter` and |Y| < `axis_off` gives right (X > 0) or left (X < 0);
  - |Y| > `axis_enter` and |X| < `axis_off` gives up (Y > 0) or down (Y < 0);
  - any other sample lies in the hysteresis band, keeps the current state, and clears the debounce run.
- R5: A candidate that differs from the current state is accepted on the event where it has been seen on `dwell_count` consecutive events, and `dwell_count` values 0 and 1 both accept on the first event. A different candidate restarts the run at one, and a candidate equal to the current state clears it.
- R6: On acceptance, the old current state moves into the previous-state output and `change_pulse` is high for exactly one cycle, aligned with the new state.
- R7: `irq_pulse` accompanies `change_pulse` only when the `state_mask` bit of the newly entered state is 1 (mask bit positions follow the R1 encoding).
- R8: While `enable` is low, strobes are ignored and the state is held. The debounce run is cleared, so a run interrupted by a disabled cycle starts over.
- R9: While `rd_hold` is high, the state outputs do not change. The newest strobe received during the hold is applied in the first cycle with `rd_hold` low; if a live strobe arrives in that same cycle, the live strobe wins.
- R10: The most negative sample code counts as magnitude 2^(AW-1), so a full-scale negative X selects left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Function enable |
| smp_valid | input | 1 | Output-data-rate sample strobe |
| rd_hold | input | 1 | Freeze state outputs while a read is in progress |
| acc_x | input | AW | Signed X sample |
| acc_y | input | AW | Signed Y sample |
| acc_z | input | AW | Signed Z sample |
| tilt_limit | input | AW | In-plane magnitude below which the device is flat |
| axis_enter | input | AW | Dominant-axis magnitude needed to enter a rotation state |
| axis_off | input | AW | Off-axis magnitude that must not be reached |
| dwell_count | input | DW | Consecutive events required before acceptance |
| state_mask | input | 6 | Per-state interrupt enable, R1 bit order |
| cur_state | output | 8 | Current orientation, one-hot |
| prev_state | output | 8 | Orientation before the last accepted change |
| change_pulse | output | 1 | One-cycle pulse on accepted change |
| irq_pulse | output | 1 | Masked one-cycle interrupt pulse |

## Verification
The bench probes the tilt gate exactly at its limit and one count below, where an off-by-one comparator would wrongly report a flat device or miss it. It feeds diagonal samples and samples with an off-axis value too large, which a design without the band would turn into a rotation. For the debounce, it interrupts runs with the current state, with a competing candidate and with a disabled cycle; a counter that does not restart would accept a sample too early. It also freezes the outputs with the read hold and checks that only the newest held strobe is applied afterward, and it drives a full-scale negative X, where a narrow absolute value would wrap and select no state.

// File: rtl/orient_pkg.sv
package orient_pkg;

    localparam int NSTATE = 6;

    typedef logic [NSTATE-1:0] orient_t;

    localparam orient_t ST_LEFT  = 6'b100000;
    localparam orient_t ST_RIGHT = 6'b010000;
    localparam orient_t ST_DOWN  = 6'b001000;
    localparam orient_t ST_UP    = 6'b000100;
    localparam orient_t ST_FDOWN = 6'b000010;
    localparam orient_t ST_FUP   = 6'b000001;

    localparam int MAGW = 16;

    typedef struct packed {
        logic [MAGW-1:0] x;
        logic [MAGW-1:0] y;
    } inplane_mag_t;

    function automatic logic [MAGW-1:0] mag16(input logic signed [MAGW-1:0] v);
        logic signed [MAGW-1:0] n;
        n = -v;
        return v[MAGW-1] ? n : v;
    endfunction

endpackage

// File: rtl/orient_classifier.sv
module orient_classifier
    import orient_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic signed [AW-1:0] acc_x,
    input  logic signed [AW-1:0] acc_y,
    input  logic signed [AW-1:0] acc_z,
    input  logic [AW-1:0]        tilt_limit,
    input  logic [AW-1:0]        axis_enter,
    input  logic [AW-1:0]        axis_off,
    input  orient_t              cur,
    output orient_t              cand
);
    localparam int PADW = MAGW - AW;

    inplane_mag_t    m;
    logic [MAGW-1:0] plane_max;
    logic [MAGW-1:0] lim_w, ent_w, off_w;
    logic            flat, x_dom, y_dom;

    always_comb begin
        m.x       = mag16(MAGW'(acc_x));
        m.y       = mag16(MAGW'(acc_y));
        plane_max = (m.x > m.y) ? m.x : m.y;
        lim_w     = {{PADW{1'b0}}, tilt_limit};
        ent_w     = {{PADW{1'b0}}, axis_enter};
        off_w     = {{PADW{1'b0}}, axis_off};
        flat      = plane_max < lim_w;
        x_dom     = (m.x > ent_w) && (m.y < off_w);
        y_dom     = (m.y > ent_w) && (m.x < off_w);

        if (flat)
            cand = acc_z[AW-1] ? ST_FDOWN : ST_FUP;
        else if (x_dom)
            cand = acc_x[AW-1] ? ST_LEFT : ST_RIGHT;
        else if (y_dom)
            cand = acc_y[AW-1] ? ST_DOWN : ST_UP;
        else
            cand = cur;
    end

endmodule

// File: rtl/orient_debounce.sv
module orient_debounce
    import orient_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          evt,
    input  orient_t       cand,
    input  orient_t       cur,
    input  logic [DW-1:0] limit,
    output logic          accept
);
    localparam logic [DW:0] ONE = {{DW{1'b0}}, 1'b1};

    logic [DW-1:0] run_q;
    orient_t       last_q;
    logic [DW:0]   run_next;
    logic          differs;

    always_comb begin
        differs = (cand != cur);
        if (run_q != '0 && cand == last_q)
            run_next = {1'b0, run_q} + ONE;
        else
            run_next = ONE;
        accept = evt && differs && (run_next >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run_q  <= '0;
            last_q <= '0;
        end else if (evt) begin
            last_q <= cand;
            if (!differs || accept)
                run_q <= '0;
            else if (run_next[DW])
                run_q <= '1;
            else
                run_q <= run_next[DW-1:0];
        end
    end

endmodule

// File: rtl/orient_state_regs.sv
module orient_state_regs
    import orient_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    accept,
    input  orient_t cand,
    input  orient_t mask,
    output orient_t cur,
    output orient_t prev,
    output logic    chg,
    output logic    irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= ST_LEFT;
            prev <= ST_LEFT;
            chg  <= 1'b0;
            irq  <= 1'b0;
        end else begin
            chg <= accept;
            irq <= accept && ((cand & mask) != '0);
            if (accept) begin
                prev <= cur;
                cur  <= cand;
            end
        end
    end

endmodule

// File: rtl/orient_detector.sv
module orient_detector
    import orient_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 smp_valid,
    input  logic                 rd_hold,
    input  logic signed [AW-1:0] acc_x,
    input  logic signed [AW-1:0] acc_y,
    input  logic signed [AW-1:0] acc_z,
    input  logic [AW-1:0]        tilt_limit,
    input  logic [AW-1:0]        axis_enter,
    input  logic [AW-1:0]        axis_off,
    input  logic [DW-1:0]        dwell_count,
    input  logic [NSTATE-1:0]    state_mask,
    output logic [7:0]           cur_state,
    output logic [7:0]           prev_state,
    output logic                 change_pulse,
    output logic                 irq_pulse
);
    localparam int PADS = 8 - NSTATE;

    orient_t cur_q, prev_q, live_cand, pend_cand, evt_cand;
    logic    pend_v, evt, accept;

    orient_classifier #(.AW(AW)) u_cls (
        .acc_x      (acc_x),
        .acc_y      (acc_y),
        .acc_z      (acc_z),
        .tilt_limit (tilt_limit),
        .axis_enter (axis_enter),
        .axis_off   (axis_off),
        .cur        (cur_q),
        .cand       (live_cand)
    );

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pend_v    <= 1'b0;
            pend_cand <= '0;
        end else if (rd_hold) begin
            if (smp_valid) begin
                pend_v    <= 1'b1;
                pend_cand <= live_cand;
            end
        end else begin
            pend_v <= 1'b0;
        end
    end

    always_comb begin
        evt      = enable && !rd_hold && (smp_valid || pend_v);
        evt_cand = smp_valid ? live_cand : pend_cand;
    end

    orient_debounce #(.DW(DW)) u_deb (
        .clk    (clk),
        .rst    (rst),
        .en     (enable),
        .evt    (evt),
        .cand   (evt_cand),
        .cur    (cur_q),
        .limit  (dwell_count),
        .accept (accept)
    );

    orient_state_regs u_st (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .cand   (evt_cand),
        .mask   (state_mask),
        .cur    (cur_q),
        .prev   (prev_q),
        .chg    (change_pulse),
        .irq    (irq_pulse)
    );

    assign cur_state  = {{PADS{1'b0}}, cur_q};
    assign prev_state = {{PADS{1'b0}}, prev_q};

endmodule

// File: rtl/orient_detector_chk.sv
module orient_detector_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       rd_hold,
    input logic [5:0] state_mask,
    input logic [7:0] cur_state,
    input logic [7:0] prev_state,
    input logic       change_pulse,
    input logic       irq_pulse
);
    a_r1_cur_onehot: assert property (@(posedge clk) disable iff (rst)
        ($countones(cur_state[5:0]) == 1) && (cur_state[7:6] == 2'b00));

    a_r1_prev_onehot: assert property (@(posedge clk) disable iff (rst)
        ($countones(prev_state[5:0]) == 1) && (prev_state[7:6] == 2'b00));

    a_r2_move_needs_pulse: assert property (@(posedge clk) disable iff (rst)
        (cur_state != $past(cur_state)) |-> change_pulse);

    a_r6_prev_shift: assert property (@(posedge clk) disable iff (rst)
        change_pulse |-> (prev_state == $past(cur_state)) && (cur_state != prev_state));

    a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> change_pulse && ((cur_state[5:0] & $past(state_mask)) != 6'd0));

    a_r8_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(cur_state) && !change_pulse);

    a_r9_read_freeze: assert property (@(posedge clk) disable iff (rst)
        rd_hold |=> $stable(cur_state) && $stable(prev_state));

endmodule

bind orient_detector orient_detector_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .rd_hold      (rd_hold),
    .state_mask   (state_mask),
    .cur_state    (cur_state),
    .prev_state   (prev_state),
    .change_pulse (change_pulse),
    .irq_pulse    (irq_pulse)
);

// File: tb/orient_detector_test.sv
`timescale 1ns/1ps
module orient_detector_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst, enable, smp_valid, rd_hold;
    logic signed [7:0] acc_x, acc_y, acc_z;
    logic [7:0]        tilt_limit, axis_enter, axis_off, dwell_count;
    logic [5:0]        state_mask;
    logic [7:0]        cur_state, prev_state;
    logic              change_pulse, irq_pulse;

    orient_detector uut (
        .clk(clk), .rst(rst), .enable(enable), .smp_valid(smp_valid),
        .rd_hold(rd_hold), .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z),
        .tilt_limit(tilt_limit), .axis_enter(axis_enter), .axis_off(axis_off),
        .dwell_count(dwell_count), .state_mask(state_mask),
        .cur_state(cur_state), .prev_state(prev_state),
        .change_pulse(change_pulse), .irq_pulse(irq_pulse)
    );

    typedef struct packed {
        logic [7:0] cur;
        logic [7:0] prev;
        logic       chg;
        logic       irq;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;
    event  sampled;

    // monitor: pops expectations as results appear
    always @(sampled) begin
        exp_t  e;
        string t;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL monitor: result with no expectation, actual cur=%h", cur_state);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (cur_state !== e.cur || prev_state !== e.prev ||
                change_pulse !== e.chg || irq_pulse !== e.irq) begin
                n_fail++;
                $display("FAIL %s: actual cur=%h prev=%h chg=%b irq=%b expected cur=%h prev=%h chg=%b irq=%b",
                         t, cur_state, prev_state, change_pulse, irq_pulse,
                         e.cur, e.prev, e.chg, e.irq);
            end
        end
    end

    task automatic push(input logic [7:0] c, input logic [7:0] p,
                        input logic ch, input logic ir, input string t);
        exp_t e;
        e.cur = c; e.prev = p; e.chg = ch; e.irq = ir;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // one strobe; starts and ends at a falling edge
    task automatic apply(input int x, input int y, input int z,
                         input logic [7:0] c, input logic [7:0] p,
                         input logic ch, input logic ir, input string t);
        acc_x = 8'(x); acc_y = 8'(y); acc_z = 8'(z);
        smp_valid = 1'b1;
        push(c, p, ch, ir, t);
        @(posedge clk);
        #1 -> sampled;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic observe(input logic [7:0] c, input logic [7:0] p,
                           input logic ch, input logic ir, input string t);
        push(c, p, ch, ir, t);
        @(posedge clk);
        #1 -> sampled;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; enable = 1'b1; smp_valid = 1'b0; rd_hold = 1'b0;
        acc_x = 0; acc_y = 0; acc_z = 0;
        tilt_limit = 8'd28; axis_enter = 8'd55; axis_off = 8'd32;
        dwell_count = 8'd0; state_mask = 6'h3F;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        observe(8'h20, 8'h20, 0, 0, "R1 reset state");
        // flat detection
        apply(0, 0, 64,   8'h01, 8'h20, 1, 1, "R3 face-up");
        apply(0, 0, -64,  8'h02, 8'h01, 1, 1, "R3 face-down");
        // rotation states
        apply(60, 10, 0,  8'h10, 8'h02, 1, 1, "R4 right");
        apply(5, 60, 0,   8'h04, 8'h10, 1, 1, "R4 up");
        apply(45, 45, 0,  8'h04, 8'h10, 0, 0, "R4 diagonal in band");
        apply(60, 40, 0,  8'h04, 8'h10, 0, 0, "R4 off-axis too large");
        apply(-60, 0, 0,  8'h20, 8'h04, 1, 1, "R4 left");
        apply(0, -60, 0,  8'h08, 8'h20, 1, 1, "R4 down");
        apply(-128, 0, 0, 8'h20, 8'h08, 1, 1, "R10 full-scale negative X");
        // tilt gate boundary
        apply(28, 0, 64,  8'h20, 8'h08, 0, 0, "R3 magnitude equal to limit");
        apply(27, 0, 10,  8'h01, 8'h20, 1, 1, "R3 magnitude below limit");
        apply(0, 0, 0,    8'h01, 8'h20, 0, 0, "R3 zero Z is face-up");
        // input change without strobe
        acc_x = 8'sd60; acc_y = 8'sd0; acc_z = 8'sd0;
        observe(8'h01, 8'h20, 0, 0, "R2 no strobe no update");

        // debounce with a run length of three
        dwell_count = 8'd3;
        apply(0, 0, -64,  8'h01, 8'h20, 0, 0, "R5 run 1");
        apply(0, 0, -64,  8'h01, 8'h20, 0, 0, "R5 run 2");
        apply(0, 0, -64,  8'h02, 8'h01, 1, 1, "R5 run 3 accepts");
        apply(0, 0, 64,   8'h02, 8'h01, 0, 0, "R5 run 1");
        apply(0, 0, 64,   8'h02, 8'h01, 0, 0, "R5 run 2");
        apply(0, 0, -64,  8'h02, 8'h01, 0, 0, "R5 current clears run");
        apply(0, 0, 64,   8'h02, 8'h01, 0, 0, "R5 restart 1");
        apply(0, 0, 64,   8'h02, 8'h01, 0, 0, "R5 restart 2");
        apply(0, 0, 64,   8'h01, 8'h02, 1, 1, "R5 restart 3 accepts");
        apply(0, 0, -64,  8'h01, 8'h02, 0, 0, "R5 fd 1");
        apply(0, 0, -64,  8'h01, 8'h02, 0, 0, "R5 fd 2");
        apply(60, 0, 0,   8'h01, 8'h02, 0, 0, "R5 competitor restarts");
        apply(60, 0, 0,   8'h01, 8'h02, 0, 0, "R5 right 2");
        apply(60, 0, 0,   8'h10, 8'h01, 1, 1, "R5 right 3 accepts");
        dwell_count = 8'd1;
        apply(0, 60, 0,   8'h04, 8'h10, 1, 1, "R5 run length one");

        // interrupt masking
        dwell_count = 8'd0;
        state_mask = 6'h3E;
        apply(0, 0, 64,   8'h01, 8'h04, 1, 0, "R7 masked face-up");
        apply(0, 0, -64,  8'h02, 8'h01, 1, 1, "R7 unmasked face-down");
        state_mask = 6'h3F;

        // enable
        enable = 1'b0;
        apply(60, 0, 0,   8'h02, 8'h01, 0, 0, "R8 disabled strobe ignored");
        enable = 1'b1;
        dwell_count = 8'd2;
        apply(60, 0, 0,   8'h02, 8'h01, 0, 0, "R8 run 1");
        enable = 1'b0;
        observe(8'h02, 8'h01, 0, 0, "R8 disabled cycle");
        enable = 1'b1;
        apply(60, 0, 0,   8'h02, 8'h01, 0, 0, "R8 run restarted");
        apply(60, 0, 0,   8'h10, 8'h02, 1, 1, "R8 run completes");

        // read hold
        dwell_count = 8'd0;
        rd_hold = 1'b1;
        apply(0, 0, 64,   8'h10, 8'h02, 0, 0, "R9 frozen during hold");
        rd_hold = 1'b0;
        observe(8'h01, 8'h10, 1, 1, "R9 held strobe applied");
        rd_hold = 1'b1;
        apply(0, 0, -64,  8'h01, 8'h10, 0, 0, "R9 first held strobe");
        apply(0, 60, 0,   8'h01, 8'h10, 0, 0, "R9 second held strobe");
        rd_hold = 1'b0;
        observe(8'h04, 8'h01, 1, 1, "R9 newest held strobe wins");
        observe(8'h04, 8'h01, 0, 0, "R6 pulse lasts one cycle");
        rd_hold = 1'b1;
        apply(0, 0, 64,   8'h04, 8'h01, 0, 0, "R9 held face-up");
        rd_hold = 1'b0;
        apply(0, -60, 0,  8'h08, 8'h04, 1, 1, "R9 live strobe beats held");

        @(negedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL monitor: %0d expectations never checked, expected 0", exp_q.size());
        end
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule